// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the status and control word for a single downstream port of a USB 1.1 root hub, laid out the way an OHCI-style host controller driver expects. Software reaches it through a 32-bit register interface: the read word is always available on `rd_data`, and a write is a one-cycle pulse on `wr_en` with `wr_data`. A write is not stored as it stands. Each set bit is a command: set or clear enable, set or clear suspend, start a port reset, switch port power on or off, or clear a change flag.

The port side supplies three inputs. The first is the attach level. The second is the speed detect. The third is a one-cycle pulse for a disconnect or bus error. The block turns these into live status bits and into change flags that stay set until cleared. It also times the two sequences that software starts but does not pace. One is the port reset. The other is the resume that ends a suspend, made of resume signalling, a low-speed end-of-packet interval and a synchronisation delay. Each interval is a tick count set by a parameter.

Top module: `rh_port_ctl`

## Requirements
- R1: After reset `rd_data` reads 32'h0000_0100. Port power (bit 8) is 1 and every other bit is 0.
- R2: Bits 31..21, 19, 15..10 and 7..5 always read 0, and writing 1 to them changes nothing. Bit 3 also always reads 0.
- R3: Bit 0 (connected) follows `dev_connect` one clock later. On attach, bit 9 captures `dev_lowspeed` (1 = low speed). On detach, bits 0, 1, 2, 4 and 9 all clear at the same edge. Both attach and detach set bit 16.
- R4: The change flags are bit 16 (connect), 17 (enable), 18 (suspend completed) and 20 (reset completed). Writing 1 to a flag clears it and writing 0 leaves it alone. If a set event and a clear fall in the same cycle, the flag ends up set.
- R5: Writing 1 to bit 1 sets enable (bit 1) and writing 1 to bit 0 clears it. If both are written together, clear wins. Neither write sets bit 17.
- R6: On a connected port, writing 1 to bit 4 holds bit 4 at 1 for exactly RESET_TICKS clocks. At the edge where it drops, bit 20 and bit 1 become 1.
- R7: On a connected port, writing 1 to bit 2 sets suspend. While suspended, writing 1 to bit 3 starts a resume that lasts RESUME_TICKS+EOP_TICKS+SYNC_TICKS clocks. Bit 2 stays 1 until that resume ends, and then bit 2 clears and bit 18 sets.
- R8: A write of 1 to bit 1, 2 or 4 while bit 0 is 0 performs no action, and bit 16 is set instead.
- R9: A `port_fault` pulse while enabled clears bit 1 and sets bit 17. While not enabled, it has no effect.
- R10: Writing 1 to bit 9 clears port power (bit 8) and writing 1 to bit 8 sets it. If both are written together, clear wins.
- R11: A detach during a reset or a resume stops it at once. Neither bit 20 nor bit 18 is set afterwards.
- R12: While a reset or resume is running, new reset and clear-suspend commands are ignored, and the running interval ends on its original schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 32 | Write command word |
| dev_connect | input | 1 | Device attached level from the port |
| dev_lowspeed | input | 1 | Low-speed detect, sampled on attach |
| port_fault | input | 1 | One-cycle disconnect or error event |
| rd_data | output | 32 | Status and change-flag word |

## Verification
The assertions assume that `port_fault` and `wr_en` are single-clock pulses and that `dev_connect` and `dev_lowspeed` already belong to the clock domain. They also assume every tick parameter is at least 1. The stimulus drives all inputs on the falling edge, so each level is stable for a whole cycle. It toggles the attach level, faults and writes at random over many cycles, together with directed cases. Those cases place a detach in the middle of a sequence, a flag clear in the same cycle as a flag set, and conflicting command bits in one write.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

  // command / status bit positions (driver visible, behaviour depends on them)
  localparam int B_CLR_EN   = 0;
  localparam int B_SET_EN   = 1;
  localparam int B_SET_SUSP = 2;
  localparam int B_CLR_SUSP = 3;
  localparam int B_SET_RST  = 4;
  localparam int B_SET_PWR  = 8;
  localparam int B_CLR_PWR  = 9;
  localparam int B_CSC      = 16;
  localparam int B_PESC     = 17;
  localparam int B_PSSC     = 18;
  localparam int B_PRSC     = 20;

  // change-flag indices inside the flag bank
  localparam int NFLAG  = 4;
  localparam int F_CONN = 0;
  localparam int F_EN   = 1;
  localparam int F_SUSP = 2;
  localparam int F_RST  = 3;

  // bits that carry no command (reserved plus the constant overcurrent change)
  localparam logic [31:0] IGNORED_MASK = 32'hFFE8_FCE0;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RESET  = 3'd1,
    PH_RESUME = 3'd2,
    PH_LSEOP  = 3'd3,
    PH_SYNC   = 3'd4
  } rh_phase_e;

  typedef struct packed {
    logic             clr_en;
    logic             set_en;
    logic             set_susp;
    logic             clr_susp;
    logic             set_rst;
    logic             set_pwr;
    logic             clr_pwr;
    logic [NFLAG-1:0] w1c;
    logic             ign;
  } rh_cmd_t;

  typedef struct packed {
    logic ccs;
    logic pes;
    logic pss;
    logic prs;
    logic pps;
    logic lsda;
  } rh_stat_t;

  function automatic logic [NFLAG-1:0] flag_field(logic [31:0] d);
    logic [NFLAG-1:0] f;
    f[F_CONN] = d[B_CSC];
    f[F_EN]   = d[B_PESC];
    f[F_SUSP] = d[B_PSSC];
    f[F_RST]  = d[B_PRSC];
    return f;
  endfunction

  function automatic logic [31:0] pack_word(rh_stat_t s, logic [NFLAG-1:0] f);
    logic [31:0] w;
    w = '0;
    w[B_CLR_EN]   = s.ccs;
    w[B_SET_EN]   = s.pes;
    w[B_SET_SUSP] = s.pss;
    w[B_SET_RST]  = s.prs;
    w[B_SET_PWR]  = s.pps;
    w[B_CLR_PWR]  = s.lsda;
    w[B_CSC]      = f[F_CONN];
    w[B_PESC]     = f[F_EN];
    w[B_PSSC]     = f[F_SUSP];
    w[B_PRSC]     = f[F_RST];
    return w;
  endfunction

endpackage

// File: rtl/rh_port_cmd.sv
module rh_port_cmd
  import rh_port_pkg::*;
(
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output rh_cmd_t     cmd
);

  always_comb begin
    cmd          = '0;
    cmd.clr_en   = wr_en & wr_data[B_CLR_EN];
    cmd.set_en   = wr_en & wr_data[B_SET_EN];
    cmd.set_susp = wr_en & wr_data[B_SET_SUSP];
    cmd.clr_susp = wr_en & wr_data[B_CLR_SUSP];
    cmd.set_rst  = wr_en & wr_data[B_SET_RST];
    cmd.set_pwr  = wr_en & wr_data[B_SET_PWR];
    cmd.clr_pwr  = wr_en & wr_data[B_CLR_PWR];
    cmd.w1c      = wr_en ? flag_field(wr_data) : '0;
    cmd.ign      = wr_en & (|(wr_data & IGNORED_MASK));
  end

endmodule

// File: rtl/rh_port_flags.sv
module rh_port_flags #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flag_o
);

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o[g] <= 1'b0;
      else if (set_i[g])   flag_o[g] <= 1'b1;
      else if (clr_i[g])   flag_o[g] <= 1'b0;
    end

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]); // R4
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && !clr_i[g]) |=> flag_o[g]); // R4
  end

endmodule

// File: rtl/rh_port_seq.sv
module rh_port_seq
  import rh_port_pkg::*;
#(
  parameter int RESET_TICKS  = 480000,
  parameter int RESUME_TICKS = 960000,
  parameter int EOP_TICKS    = 96,
  parameter int SYNC_TICKS   = 144000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_i,
  input  logic start_reset_i,
  input  logic start_resume_i,
  output logic idle_o,
  output logic in_reset_o,
  output logic reset_done_o,
  output logic resume_done_o
);

  localparam int MAX_AB = (RESET_TICKS > RESUME_TICKS) ? RESET_TICKS : RESUME_TICKS;
  localparam int MAX_CD = (EOP_TICKS > SYNC_TICKS) ? EOP_TICKS : SYNC_TICKS;
  localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAX_T + 1);

  rh_phase_e       state;
  logic [CW-1:0]   cnt;
  logic            last;

  function automatic logic [CW-1:0] load_for(rh_phase_e p);
    case (p)
      PH_RESET:  return CW'(RESET_TICKS - 1);
      PH_RESUME: return CW'(RESUME_TICKS - 1);
      PH_LSEOP:  return CW'(EOP_TICKS - 1);
      PH_SYNC:   return CW'(SYNC_TICKS - 1);
      default:   return '0;
    endcase
  endfunction

  function automatic rh_phase_e after(rh_phase_e p);
    case (p)
      PH_RESUME: return PH_LSEOP;
      PH_LSEOP:  return PH_SYNC;
      default:   return PH_IDLE;
    endcase
  endfunction

  assign idle_o        = (state == PH_IDLE);
  assign in_reset_o    = (state == PH_RESET);
  assign last          = !idle_o && (cnt == '0);
  assign reset_done_o  = last && (state == PH_RESET) && !abort_i;
  assign resume_done_o = last && (state == PH_SYNC) && !abort_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      cnt   <= '0;
    end else if (abort_i) begin
      state <= PH_IDLE;
      cnt   <= '0;
    end else if (idle_o) begin
      if (start_reset_i) begin
        state <= PH_RESET;
        cnt   <= load_for(PH_RESET);
      end else if (start_resume_i) begin
        state <= PH_RESUME;
        cnt   <= load_for(PH_RESUME);
      end
    end else if (last) begin
      state <= after(state);
      cnt   <= load_for(after(state));
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_PHASE_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && cnt != '0 && !abort_i) |=> $stable(state)); // R12
  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> idle_o); // R11

endmodule

// File: rtl/rh_port_ctl.sv
module rh_port_ctl
  import rh_port_pkg::*;
#(
  parameter int RESET_TICKS  = 480000,
  parameter int RESUME_TICKS = 960000,
  parameter int EOP_TICKS    = 96,
  parameter int SYNC_TICKS   = 144000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        dev_connect,
  input  logic        dev_lowspeed,
  input  logic        port_fault,
  output logic [31:0] rd_data
);

  rh_cmd_t          cmd;
  rh_stat_t         st;
  logic             ccs_q, pes_q, pss_q, pps_q, lsda_q;
  logic             attach, detach, unconn_cmd, cmd_any;
  logic             seq_idle, seq_in_reset, reset_done, resume_done;
  logic             start_reset, start_resume;
  logic [NFLAG-1:0] flag_set, flags;

  rh_port_cmd i_cmd (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  // named port events
  assign attach     = dev_connect & ~ccs_q;
  assign detach     = ~dev_connect & ccs_q;
  assign unconn_cmd = (cmd.set_en | cmd.set_susp | cmd.set_rst) & ~ccs_q;
  assign cmd_any    = cmd.clr_en | cmd.set_en | cmd.set_susp | cmd.clr_susp |
                      cmd.set_rst | cmd.set_pwr | cmd.clr_pwr | (|cmd.w1c);

  assign start_reset  = cmd.set_rst & ccs_q & ~detach;
  assign start_resume = cmd.clr_susp & pss_q & ~detach;

  rh_port_seq #(
    .RESET_TICKS  (RESET_TICKS),
    .RESUME_TICKS (RESUME_TICKS),
    .EOP_TICKS    (EOP_TICKS),
    .SYNC_TICKS   (SYNC_TICKS)
  ) i_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .abort_i        (detach),
    .start_reset_i  (start_reset),
    .start_resume_i (start_resume),
    .idle_o         (seq_idle),
    .in_reset_o     (seq_in_reset),
    .reset_done_o   (reset_done),
    .resume_done_o  (resume_done)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[F_CONN] = attach | detach | unconn_cmd;
    flag_set[F_EN]   = port_fault & pes_q;
    flag_set[F_SUSP] = resume_done;
    flag_set[F_RST]  = reset_done;
  end

  rh_port_flags #(.NF(NFLAG)) i_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (cmd.w1c),
    .flag_o (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccs_q  <= 1'b0;
      pes_q  <= 1'b0;
      pss_q  <= 1'b0;
      pps_q  <= 1'b1;
      lsda_q <= 1'b0;
    end else begin
      ccs_q <= dev_connect;

      if (detach)                     pes_q <= 1'b0;
      else if (port_fault && pes_q)   pes_q <= 1'b0;
      else if (reset_done)            pes_q <= 1'b1;
      else if (cmd.clr_en)            pes_q <= 1'b0;
      else if (cmd.set_en && ccs_q)   pes_q <= 1'b1;

      if (detach)                     pss_q <= 1'b0;
      else if (resume_done)           pss_q <= 1'b0;
      else if (cmd.set_susp && ccs_q) pss_q <= 1'b1;

      if (cmd.clr_pwr)                pps_q <= 1'b0;
      else if (cmd.set_pwr)           pps_q <= 1'b1;

      if (detach)                     lsda_q <= 1'b0;
      else if (attach)                lsda_q <= dev_lowspeed;
    end
  end

  always_comb begin
    st      = '0;
    st.ccs  = ccs_q;
    st.pes  = pes_q;
    st.pss  = pss_q;
    st.prs  = seq_in_reset;
    st.pps  = pps_q;
    st.lsda = lsda_q;
  end

  assign rd_data = pack_word(st, flags);

  AST_DETACH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    detach |=> (!ccs_q && !pes_q && !pss_q && !lsda_q && !seq_in_reset)); // R3
  AST_RESET_NEEDS_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_in_reset |-> ccs_q); // R6
  AST_RESET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_done && !(port_fault && pes_q)) |=> (pes_q && flags[F_RST])); // R6
  AST_RESUME_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    resume_done |=> (!pss_q && flags[F_SUSP])); // R7
  AST_UNCONN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    unconn_cmd |=> (flags[F_CONN] && !seq_in_reset)); // R8
  AST_FAULT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (port_fault && pes_q) |=> (!pes_q && flags[F_EN])); // R9
  AST_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr_pwr |=> !pps_q); // R10
  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (detach && !seq_idle) |=> !seq_in_reset); // R11
  AST_IGNORED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.ign && !cmd_any && !attach && !detach && !port_fault && seq_idle)
      |=> $stable(rd_data)); // R2

endmodule

// File: tb/test_rh_port_ctl.sv
`timescale 1ns/1ps
module test_rh_port_ctl;

  localparam int RST_T = 12;
  localparam int RES_T = 6;
  localparam int EOP_T = 2;
  localparam int SYN_T = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        dev_connect = 1'b0;
  logic        dev_lowspeed = 1'b0;
  logic        port_fault = 1'b0;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  rh_port_ctl #(
    .RESET_TICKS(RST_T), .RESUME_TICKS(RES_T), .EOP_TICKS(EOP_T), .SYNC_TICKS(SYN_T)
  ) i_rh_port_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .dev_connect(dev_connect), .dev_lowspeed(dev_lowspeed),
    .port_fault(port_fault), .rd_data(rd_data)
  );

  // behavioural reference model
  bit m_ccs, m_pes, m_pss, m_pps, m_ls;
  bit m_csc, m_pesc, m_pssc, m_prsc;
  int m_ph, m_cnt;

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    w[0] = m_ccs; w[1] = m_pes; w[2] = m_pss; w[4] = (m_ph == 1);
    w[8] = m_pps; w[9] = m_ls;
    w[16] = m_csc; w[17] = m_pesc; w[18] = m_pssc; w[20] = m_prsc;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ccs = 0; m_pes = 0; m_pss = 0; m_pps = 1; m_ls = 0;
      m_csc = 0; m_pesc = 0; m_pssc = 0; m_prsc = 0;
      m_ph = 0; m_cnt = 0;
    end else begin
      bit att, det, idle, rdone, sdone, go_rst, go_res;
      bit n_pes, n_pss, n_pps, n_ls, s_csc;
      att = dev_connect && !m_ccs;
      det = !dev_connect && m_ccs;
      idle = (m_ph == 0);
      rdone = 0; sdone = 0;
      if (det) begin
        m_ph = 0; m_cnt = 0;
      end else if (!idle) begin
        if (m_cnt > 1) m_cnt--;
        else begin
          case (m_ph)
            1: begin rdone = 1; m_ph = 0; end
            2: begin m_ph = 3; m_cnt = EOP_T; end
            3: begin m_ph = 4; m_cnt = SYN_T; end
            default: begin sdone = 1; m_ph = 0; end
          endcase
        end
      end
      go_rst = wr_en && wr_data[4] && m_ccs && !det && idle;
      go_res = wr_en && wr_data[3] && m_pss && !det && idle && !go_rst;
      if (go_rst) begin m_ph = 1; m_cnt = RST_T; end
      else if (go_res) begin m_ph = 2; m_cnt = RES_T; end

      n_pes = m_pes;
      if (det) n_pes = 0;
      else if (port_fault && m_pes) n_pes = 0;
      else if (rdone) n_pes = 1;
      else if (wr_en && wr_data[0]) n_pes = 0;
      else if (wr_en && wr_data[1] && m_ccs) n_pes = 1;

      n_pss = m_pss;
      if (det || sdone) n_pss = 0;
      else if (wr_en && wr_data[2] && m_ccs) n_pss = 1;

      n_pps = m_pps;
      if (wr_en && wr_data[9]) n_pps = 0;
      else if (wr_en && wr_data[8]) n_pps = 1;

      n_ls = m_ls;
      if (det) n_ls = 0;
      else if (att) n_ls = dev_lowspeed;

      s_csc = att || det || (wr_en && (wr_data[1] || wr_data[2] || wr_data[4]) && !m_ccs);
      if (port_fault && m_pes) m_pesc = 1; else if (wr_en && wr_data[17]) m_pesc = 0;
      if (s_csc) m_csc = 1; else if (wr_en && wr_data[16]) m_csc = 0;
      if (sdone) m_pssc = 1; else if (wr_en && wr_data[18]) m_pssc = 0;
      if (rdone) m_prsc = 1; else if (wr_en && wr_data[20]) m_prsc = 0;

      m_pes = n_pes; m_pss = n_pss; m_pps = n_pps; m_ls = n_ls;
      m_ccs = dev_connect;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // model comparison every cycle, away from the rising edge
  always @(negedge clk) if (rst_n && !done) chk(cur_req, rd_data, model_word());

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    cur_req = "R1";
    chk("R1", rd_data, 32'h0000_0100);
    tick(1);

    cur_req = "R2";
    wr(32'hFFE8_FCE0);
    chk("R2", rd_data, 32'h0000_0100);

    cur_req = "R3";
    dev_connect = 1; dev_lowspeed = 1;
    tick(1);
    chk("R3", rd_data, 32'h0001_0301);

    cur_req = "R4";
    wr(32'h0);
    chk("R4", rd_data, 32'h0001_0301);
    wr(32'h0001_0000);
    chk("R4", rd_data, 32'h0000_0301);

    cur_req = "R5";
    wr(32'h2); chk("R5", rd_data, 32'h0000_0303);
    wr(32'h1); chk("R5", rd_data, 32'h0000_0301);
    wr(32'h3); chk("R5", rd_data, 32'h0000_0301);
    wr(32'h2); chk("R5", rd_data, 32'h0000_0303);

    cur_req = "R6";
    wr(32'h10); chk("R6", rd_data, 32'h0000_0313);
    tick(RST_T - 1); chk("R6", rd_data, 32'h0000_0313);
    tick(1); chk("R6", rd_data, 32'h0010_0303);
    wr(32'h0010_0000); chk("R6", rd_data, 32'h0000_0303);

    cur_req = "R12";
    wr(32'h10);
    tick(2);
    wr(32'h10);
    wr(32'h8);
    tick(RST_T - 5); chk("R12", rd_data, 32'h0000_0313);
    tick(1); chk("R12", rd_data, 32'h0010_0303);
    wr(32'h0010_0000);

    cur_req = "R7";
    wr(32'h4); chk("R7", rd_data, 32'h0000_0307);
    wr(32'h8);
    tick(RES_T + EOP_T + SYN_T - 1); chk("R7", rd_data, 32'h0000_0307);
    tick(1); chk("R7", rd_data, 32'h0004_0303);
    wr(32'h0004_0000); chk("R7", rd_data, 32'h0000_0303);

    cur_req = "R9";
    port_fault = 1; tick(1); port_fault = 0;
    chk("R9", rd_data, 32'h0002_0301);
    wr(32'h0002_0000);
    port_fault = 1; tick(1); port_fault = 0;
    chk("R9", rd_data, 32'h0000_0301);

    cur_req = "R10";
    wr(32'h200); chk("R10", rd_data, 32'h0000_0201);
    wr(32'h100); chk("R10", rd_data, 32'h0000_0301);
    wr(32'h300); chk("R10", rd_data, 32'h0000_0201);
    wr(32'h100);

    cur_req = "R11";
    wr(32'h10); chk("R11", rd_data, 32'h0000_0311);
    tick(3);
    dev_connect = 0; tick(1);
    chk("R11", rd_data, 32'h0001_0100);
    tick(RST_T); chk("R11", rd_data, 32'h0001_0100);
    wr(32'h0001_0000); chk("R11", rd_data, 32'h0000_0100);

    cur_req = "R8";
    wr(32'h16); chk("R8", rd_data, 32'h0001_0100);
    wr(32'h0001_0000);

    cur_req = "R4";
    dev_connect = 1; dev_lowspeed = 0;
    wr(32'h0001_0000);
    chk("R4", rd_data, 32'h0001_0101);
    wr(32'h0001_0000);

    cur_req = "R3";
    wr(32'h2); wr(32'h4); chk("R3", rd_data, 32'h0000_0107);
    dev_connect = 0; tick(1);
    chk("R3", rd_data, 32'h0001_0100);
    wr(32'h0001_0000);

    cur_req = "R3";
    for (int i = 0; i < 4000; i++) begin
      wr_en       = ($urandom_range(0, 3) == 0);
      wr_data     = $urandom & 32'hFFFF_FEFF | ($urandom_range(0, 1) ? 32'h100 : 32'h0);
      port_fault  = ($urandom_range(0, 31) == 0);
      if ($urandom_range(0, 63) == 0) dev_connect = ~dev_connect;
      dev_lowspeed = $urandom_range(0, 1);
      tick(1);
    end
    wr_en = 0; port_fault = 0;
    tick(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1'b1;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule